// File: doc/BRIEF.md
# 4B/5B Receive Code-Group Decoder

This block sits in a 100BASE-TX receive path after code-group alignment. It takes one aligned 5-bit code group per strobe. It turns each code group into a 4-bit receive nibble and a two-bit symbol class. The classes are data, idle, control and violation. A receive-error flag marks a violation only when it lands inside a frame, which is when the receive-data-valid qualifier is high.

The block does not check frame boundaries. The upstream logic drives the qualifier from its own start-of-stream and end-of-stream detection, and this decoder simply uses it. All three outputs come from a single register stage. While reset is asserted, and in any cycle without a strobe, the outputs show idle.

Top module: `sym5_rx_decoder`

## Requirements
- R1: Each of the sixteen data code groups gives class data (encoding 00) and its nibble, one cycle after the strobe: 11110→0x0, 01001→0x1, 10100→0x2, 10101→0x3, 01010→0x4, 01011→0x5, 01110→0x6, 01111→0x7, 10010→0x8, 10011→0x9, 10110→0xA, 10111→0xB, 11010→0xC, 11011→0xD, 11100→0xE, 11101→0xF.
- R2: Code group 11111 gives class idle (encoding 01) with nibble 0x0.
- R3: Code groups 11000, 10001, 01101, 00111 and 00100 give class control (encoding 10) with nibble 0x0, never class data.
- R4: Code groups 00010, 00011, 00101, 01000, 01100 and 10000 give class violation (encoding 11) with nibble 0x0.
- R5: Every other 5-bit value (00000, 00001, 00110, 11001) also gives class violation with nibble 0x0.
- R6: A violation strobed while receive-data-valid is high raises the error flag in the output cycle.
- R7: A violation strobed while receive-data-valid is low reports class violation with the error flag low.
- R8: The error flag stays low for data, idle and control code groups, whatever the qualifier level.
- R9: The outputs change exactly one clock after the strobe. A cycle with the strobe low gives class idle, nibble 0x0 and error low in the next cycle, whatever the code group and qualifier are.
- R10: While the synchronous active-high reset is asserted, the outputs show class idle, nibble 0x0 and error low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grp_i | input | 5 | Aligned received code group |
| grp_vld_i | input | 1 | Strobe: grp_i is valid this cycle |
| rx_dv_i | input | 1 | Receive-data-valid qualifier (inside a frame) |
| nib_o | output | 4 | Decoded nibble (0x0 for non-data) |
| cls_o | output | 2 | Class: 00 data, 01 idle, 10 control, 11 violation |
| rx_err_o | output | 1 | Receive error: violation seen inside a frame |

## Verification
Classifying a code group as a violation and deciding whether to raise the error flag happen in the same output cycle. Both depend on the strobe and the qualifier sampled on the same edge. The bench drives every violation code group both with the qualifier high and with it low. It also drives control and data groups with the qualifier high and violation groups with the strobe low. For each case it checks the class and the error flag together, so an error raised without a violation, or a violation without its flag inside a frame, shows up as a mismatch.

// File: rtl/sym5_pkg.sv
package sym5_pkg;
  localparam int GRP_W = 5;
  localparam int NIB_W = 4;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_DATA = 2'b00,
    CLS_IDLE = 2'b01,
    CLS_CTRL = 2'b10,
    CLS_VIOL = 2'b11
  } sym_cls_e;
endpackage

// File: rtl/sym5_lut.sv
module sym5_lut
  import sym5_pkg::*;
(
  input  logic [GRP_W-1:0] grp_i,
  output logic [NIB_W-1:0] nib_o,
  output sym_cls_e         cls_o
);
  // Combinational lookup of the full 32-entry code space.
  always_comb begin
    nib_o = '0;
    cls_o = CLS_DATA;
    case (grp_i)
      5'b11110: nib_o = 4'h0;
      5'b01001: nib_o = 4'h1;
      5'b10100: nib_o = 4'h2;
      5'b10101: nib_o = 4'h3;
      5'b01010: nib_o = 4'h4;
      5'b01011: nib_o = 4'h5;
      5'b01110: nib_o = 4'h6;
      5'b01111: nib_o = 4'h7;
      5'b10010: nib_o = 4'h8;
      5'b10011: nib_o = 4'h9;
      5'b10110: nib_o = 4'hA;
      5'b10111: nib_o = 4'hB;
      5'b11010: nib_o = 4'hC;
      5'b11011: nib_o = 4'hD;
      5'b11100: nib_o = 4'hE;
      5'b11101: nib_o = 4'hF;
      5'b11111: cls_o = CLS_IDLE;
      5'b11000, 5'b10001, 5'b01101,
      5'b00111, 5'b00100: cls_o = CLS_CTRL;
      default:            cls_o = CLS_VIOL;
    endcase
  end
endmodule

// File: rtl/sym5_out_reg.sv
module sym5_out_reg
  import sym5_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic             dv_i,
  input  logic [NIB_W-1:0] nib_i,
  input  sym_cls_e         cls_i,
  output logic [NIB_W-1:0] nib_o,
  output sym_cls_e         cls_o,
  output logic             err_o
);
  always_ff @(posedge clk) begin
    if (rst || !vld_i) begin
      nib_o <= '0;
      cls_o <= CLS_IDLE;
      err_o <= 1'b0;
    end else begin
      nib_o <= nib_i;
      cls_o <= cls_i;
      err_o <= dv_i && (cls_i == CLS_VIOL);
    end
  end

  // R6: in-frame violation flagged
  a_r6_viol_in_frame: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(vld_i && dv_i && cls_i == CLS_VIOL)) |-> err_o);
  // R7: no error outside a frame
  a_r7_no_err_out_of_frame: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!dv_i)) |-> !err_o);
  // R8: error only accompanies a violation
  a_r8_err_only_viol: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (cls_o == CLS_VIOL));
  // R9: missing strobe yields idle
  a_r9_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!vld_i)) |-> (cls_o == CLS_IDLE && nib_o == '0));
  // R2: non-data classes carry a zero nibble
  a_r2_zero_nib_non_data: assert property (@(posedge clk) disable iff (rst)
    (cls_o != CLS_DATA) |-> (nib_o == '0));
endmodule

// File: rtl/sym5_rx_decoder.sv
module sym5_rx_decoder
  import sym5_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] grp_i,
  input  logic             grp_vld_i,
  input  logic             rx_dv_i,
  output logic [NIB_W-1:0] nib_o,
  output logic [CLS_W-1:0] cls_o,
  output logic             rx_err_o
);
  logic [NIB_W-1:0] lut_nib;
  sym_cls_e         lut_cls;
  sym_cls_e         reg_cls;

  sym5_lut lut_i (
    .grp_i (grp_i),
    .nib_o (lut_nib),
    .cls_o (lut_cls)
  );

  sym5_out_reg reg_i (
    .clk   (clk),
    .rst   (rst),
    .vld_i (grp_vld_i),
    .dv_i  (rx_dv_i),
    .nib_i (lut_nib),
    .cls_i (lut_cls),
    .nib_o (nib_o),
    .cls_o (reg_cls),
    .err_o (rx_err_o)
  );

  assign cls_o = reg_cls;

  // R10: reset leaves outputs idle
  a_r10_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (cls_o == CLS_IDLE && nib_o == '0 && !rx_err_o));
endmodule

// File: tb/sym5_rx_decoder_tb_top.sv
module sym5_rx_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] grp;
  logic       vld;
  logic       dv;
  logic [3:0] nib;
  logic [1:0] cls;
  logic       err;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sym5_rx_decoder dut_i (
    .clk(clk), .rst(rst), .grp_i(grp), .grp_vld_i(vld), .rx_dv_i(dv),
    .nib_o(nib), .cls_o(cls), .rx_err_o(err)
  );

  // {code, dv, nibble, class, err} ; class 0 data 1 idle 2 ctrl 3 viol
  localparam int NV = 32;
  localparam logic [12:0] VEC [NV] = '{
    {5'b11110,1'b1,4'h0,2'd0,1'b0}, // R1
    {5'b01001,1'b0,4'h1,2'd0,1'b0},
    {5'b10100,1'b1,4'h2,2'd0,1'b0},
    {5'b10101,1'b0,4'h3,2'd0,1'b0},
    {5'b01010,1'b1,4'h4,2'd0,1'b0},
    {5'b01011,1'b0,4'h5,2'd0,1'b0},
    {5'b01110,1'b1,4'h6,2'd0,1'b0},
    {5'b01111,1'b0,4'h7,2'd0,1'b0},
    {5'b10010,1'b1,4'h8,2'd0,1'b0},
    {5'b10011,1'b0,4'h9,2'd0,1'b0},
    {5'b10110,1'b1,4'hA,2'd0,1'b0},
    {5'b10111,1'b0,4'hB,2'd0,1'b0},
    {5'b11010,1'b1,4'hC,2'd0,1'b0},
    {5'b11011,1'b0,4'hD,2'd0,1'b0},
    {5'b11100,1'b1,4'hE,2'd0,1'b0},
    {5'b11101,1'b1,4'hF,2'd0,1'b0},
    {5'b11111,1'b1,4'h0,2'd1,1'b0}, // R2
    {5'b11000,1'b1,4'h0,2'd2,1'b0}, // R3, R8
    {5'b10001,1'b1,4'h0,2'd2,1'b0},
    {5'b01101,1'b1,4'h0,2'd2,1'b0},
    {5'b00111,1'b0,4'h0,2'd2,1'b0},
    {5'b00100,1'b1,4'h0,2'd2,1'b0},
    {5'b00010,1'b1,4'h0,2'd3,1'b1}, // R4, R6
    {5'b00011,1'b0,4'h0,2'd3,1'b0}, // R4, R7
    {5'b00101,1'b1,4'h0,2'd3,1'b1},
    {5'b01000,1'b0,4'h0,2'd3,1'b0},
    {5'b01100,1'b1,4'h0,2'd3,1'b1},
    {5'b10000,1'b0,4'h0,2'd3,1'b0},
    {5'b00000,1'b1,4'h0,2'd3,1'b1}, // R5
    {5'b00001,1'b0,4'h0,2'd3,1'b0},
    {5'b00110,1'b1,4'h0,2'd3,1'b1},
    {5'b11001,1'b1,4'h0,2'd3,1'b1}
  };

  task automatic check(input string req, input logic [3:0] en,
                       input logic [1:0] ec, input logic ee);
    n_chk++;
    if (nib !== en || cls !== ec || err !== ee) begin
      n_bad++;
      $display("FAIL %s: got nib=%h cls=%0d err=%b expected nib=%h cls=%0d err=%b",
               req, nib, cls, err, en, ec, ee);
    end
  endtask

  // drive at negedge; the register captures at the next posedge; sample at the following negedge
  task automatic apply(input logic [4:0] g, input logic v, input logic d);
    grp = g; vld = v; dv = d;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; grp = 5'b00010; vld = 1'b1; dv = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset idle", 4'h0, 2'd1, 1'b0);
    rst = 1'b0;
    foreach (VEC[i]) begin
      apply(VEC[i][12:8], 1'b1, VEC[i][7]);
      check($sformatf("R1-table entry %0d (R1/R2/R3/R4/R5/R6/R7/R8)", i),
            VEC[i][6:3], VEC[i][2:1], VEC[i][0]);
    end
    // R6/R7: every listed violation at both qualifier levels
    foreach (VEC[i]) if (VEC[i][2:1] == 2'd3) begin
      apply(VEC[i][12:8], 1'b1, ~VEC[i][7]);
      check("R6 R7 violation vs qualifier", 4'h0, 2'd3, ~VEC[i][7]);
    end
    // R9: strobe low with a violation in frame gives idle, no error
    apply(5'b00010, 1'b0, 1'b1);
    check("R9 no strobe", 4'h0, 2'd1, 1'b0);
    apply(5'b11101, 1'b0, 1'b0);
    check("R9 no strobe data", 4'h0, 2'd1, 1'b0);
    // R9: latency of exactly one cycle
    grp = 5'b11101; vld = 1'b1; dv = 1'b0;
    @(posedge clk); #1;
    check("R9 one-cycle latency", 4'hF, 2'd0, 1'b0);
    grp = 5'b01001;
    @(negedge clk);
    check("R9 not yet updated", 4'hF, 2'd0, 1'b0);
    @(negedge clk);
    check("R9 updated", 4'h1, 2'd0, 1'b0);
    // R8: data in frame carries no error
    apply(5'b10111, 1'b1, 1'b1);
    check("R8 data in frame", 4'hB, 2'd0, 1'b0);
    // R10: reset mid-stream
    grp = 5'b00000; vld = 1'b1; dv = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R10 reset mid-stream", 4'h0, 2'd1, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 after reset", 4'h0, 2'd3, 1'b1);
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule